// File: doc/BRIEF.md
# Configuration Space Access Unit

This block holds the 256-byte configuration register file of one bus function and the front end that serves configuration reads and writes to it. Each request carries a 24-bit address made of a bus number, a device/function number and a register offset, a length of 1, 2 or 4 bytes and, for writes, a 32-bit data word. The unit answers only when the bus number and device/function match its own parameters. Reads complete one cycle later, in little-endian byte order.

Writes go through two paths. An aligned 4-byte write to a base-address register that has a nonzero size, or to the expansion-ROM register, is size-masked as a whole. The type bits of a base-address register are kept, and so is the enable bit of the ROM register. Every other write is applied byte by byte. A byte-protection map that depends on the stored header type decides which bytes change, and reserved command bits are cleared. Any write that touches the command word raises a one-cycle pulse so the address decoder can rebuild its windows. When the bridge parameter is set, the unit starts with bridge reset values and captures the secondary bus number it is given.

Top module: `cfgspc_unit`

## Requirements
- R1: The address is split as bus = reqAddr[23:16], device/function = reqAddr[15:8], offset = reqAddr[7:0]. A write whose bus or device/function differs from MY_BUS/MY_DEVFN changes no register, gives no command pulse and leaves the secondary bus unchanged.
- R2: A read that misses returns all ones at the requested width: 0x000000FF for length 1, 0x0000FFFF for length 2, and 0xFFFFFFFF for length 4 or any other length code.
- R3: A read that hits sets rdValid in the cycle after the request. rdData holds byte offset+k in bits [8k+7:8k], and the bytes above the access width read as zero.
- R4: A 4-byte read at an offset above 0xFC returns only 2 bytes. A 2-byte read (or a 4-byte read that has fallen back) at an offset above 0xFE returns only 1 byte.
- R5: A 4-byte write at offset 0x10+4n (n below NUM_BARS) to a base-address register whose size is nonzero stores (data AND NOT(size-1)) OR type.
- R6: A 4-byte write at offset 0x30, when ROM_SIZE is nonzero, stores data AND (NOT(ROM_SIZE-1) OR 1).
- R7: Every other write is applied one byte per lane, lane k taking data bits [8k+7:8k] to offset+k. Lanes that would pass offset 0xFF are dropped.
- R8: With header type 0x00 or 0x80 at offset 0x0E, byte writes to 0x00-0x03, 0x06-0x0B, 0x0E, 0x10-0x27, 0x2C-0x2F, 0x30-0x33 and 0x3D have no effect.
- R9: With any other header type, the protected offsets are 0x00-0x03, 0x06-0x0B, 0x0E, 0x2C-0x2F, 0x38-0x3B and 0x3D.
- R10: A byte written to offset 0x05 keeps only bits [2:0]. The other bits are stored as zero.
- R11: cmdUpdate pulses for one cycle, in the cycle after any hitting write whose byte range [offset, offset+length) overlaps 0x04-0x05, whether or not those bytes are protected. It stays low otherwise.
- R12: When IS_BRIDGE is set, a hitting write at offset 0x19 loads secBus from data[7:0], and a hitting write of length 2 or 4 at offset 0x18 loads it from data[15:8]. No other write changes secBus.
- R13: After reset, bytes 0x00-0x03 hold the vendor and device IDs and 0x0A-0x0B hold the class code. Each sized base-address register holds its type bits. The header type is 0x00, or 0x81 for a bridge. A bridge also starts with command 0x06, status 0xA0, latency timer 0x10 and secondary status 0xA0. All other bytes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 24 | Bus, device/function, offset |
| reqLen | input | 3 | Access length code: 1, 2 or 4 |
| reqWdata | input | 32 | Write data, little-endian |
| rdValid | output | 1 | Read data valid |
| rdData | output | 32 | Read data |
| cmdUpdate | output | 1 | Command word touched, remap needed |
| secBus | output | 8 | Captured secondary bus number |

## Verification
One plain function and one bridge function share a request bus, so every access must land on exactly one of them. Reads are tried at aligned offsets, at unaligned offsets and at the top of the space, which separates correct byte ordering from fallback width and from the all-ones answer for a miss. Writes of every length are aimed at protected, partly protected and free offsets, at base-address registers with and without a size, and at the ROM register. These patterns separate the whole-register masking path from the byte path, and separate the two protection maps. Writes that just touch or just miss the command word, and writes at 0x18 and 0x19 of each length, exercise the remap pulse and the bus capture.

// File: rtl/cfgspc_pkg.sv
package cfgspc_pkg;

  localparam int REG_BYTES = 256;
  localparam logic [7:0] BAR_LO     = 8'h10;
  localparam logic [7:0] ROM_OFS    = 8'h30;
  localparam logic [7:0] HDR_OFS    = 8'h0E;
  localparam logic [7:0] HDR_PLAIN  = 8'h00;
  localparam logic [7:0] HDR_BRIDGE = 8'h81;

  typedef enum logic [1:0] {RD_W1, RD_W2, RD_W4} rdWidth_e;

  typedef struct packed {
    logic       rdEn;
    logic       rdMiss;
    rdWidth_e   rdWidth;
    logic       barWr;
    logic [2:0] barSel;
    logic       romWr;
    logic [3:0] laneWe;
    logic [7:0] offset;
    logic       cmdTouch;
    logic       secCap;
    logic       secHiLane;
  } ctrlStrobe_t;

  // Byte protection map, chosen by the header type byte
  function automatic logic isProtected(input logic [7:0] off, input logic [7:0] hdr);
    logic plain, shared;
    plain  = (hdr == 8'h00) || (hdr == 8'h80);
    shared = (off <= 8'h03) || (off >= 8'h06 && off <= 8'h0B) || (off == 8'h0E) ||
             (off >= 8'h2C && off <= 8'h2F) || (off == 8'h3D);
    if (plain)
      return shared || (off >= 8'h10 && off <= 8'h27) || (off >= 8'h30 && off <= 8'h33);
    return shared || (off >= 8'h38 && off <= 8'h3B);
  endfunction

  // Bits kept on a byte write; reserved command/status bits are cleared
  function automatic logic [7:0] keepMask(input logic [7:0] off);
    case (off)
      8'h05:   return 8'h07;
      8'h06:   return 8'hF8;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/cfgspc_ctrl.sv
module cfgspc_ctrl
  import cfgspc_pkg::*;
#(
  parameter logic [7:0]              MY_BUS    = 8'h00,
  parameter logic [7:0]              MY_DEVFN  = 8'h18,
  parameter bit                      IS_BRIDGE = 1'b0,
  parameter int                      NUM_BARS  = 6,
  parameter logic [NUM_BARS*32-1:0]  BAR_SIZES = '0,
  parameter logic [31:0]             ROM_SIZE  = 32'h0
) (
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [23:0] reqAddr,
  input  logic [2:0]  reqLen,
  input  logic [7:0]  hdrType,
  output ctrlStrobe_t strb
);

  localparam int BAR_END = int'(BAR_LO) + 4 * NUM_BARS;

  logic [7:0] busF, devF, off;
  logic       hit, wrHit, dwBar, dwRom;
  logic [3:0] nBytes;
  logic [8:0] endOff;
  logic [2:0] barIdx;
  logic [7:0] barNz;

  assign {busF, devF, off} = reqAddr;
  assign hit   = (busF == MY_BUS) && (devF == MY_DEVFN);
  assign wrHit = reqValid && reqWrite && hit;

  always_comb begin
    case (reqLen)
      3'd1:    nBytes = 4'd1;
      3'd2:    nBytes = 4'd2;
      default: nBytes = 4'd4;
    endcase
  end

  assign endOff = {1'b0, off} + {5'b0, nBytes};
  assign barIdx = 3'((off - BAR_LO) >> 2);

  always_comb begin
    barNz = '0;
    for (int i = 0; i < NUM_BARS && i < 8; i++)
      barNz[i] = (BAR_SIZES[32*i +: 32] != '0);
  end

  assign dwBar = (nBytes == 4'd4) && (off[1:0] == 2'b00) && (off >= BAR_LO) &&
                 ({1'b0, off} < 9'(BAR_END)) && barNz[barIdx];
  assign dwRom = (nBytes == 4'd4) && (off == ROM_OFS) && (ROM_SIZE != '0);

  always_comb begin
    strb        = '0;
    strb.offset = off;
    strb.rdEn   = reqValid && !reqWrite;
    strb.rdMiss = !hit;
    if (!hit) begin
      if (nBytes == 4'd1)      strb.rdWidth = RD_W1;
      else if (nBytes == 4'd2) strb.rdWidth = RD_W2;
      else                     strb.rdWidth = RD_W4;
    end else if (nBytes == 4'd4 && off <= 8'hFC) begin
      strb.rdWidth = RD_W4;
    end else if (nBytes >= 4'd2 && off <= 8'hFE) begin
      strb.rdWidth = RD_W2;
    end else begin
      strb.rdWidth = RD_W1;
    end

    if (wrHit) begin
      if (dwBar) begin
        strb.barWr  = 1'b1;
        strb.barSel = barIdx;
      end else if (dwRom) begin
        strb.romWr = 1'b1;
      end else begin
        for (int i = 0; i < 4; i++)
          if ((4'(i) < nBytes) && (({1'b0, off} + 9'(i)) <= 9'd255) &&
              !isProtected(off + 8'(i), hdrType))
            strb.laneWe[i] = 1'b1;
      end
      strb.cmdTouch  = (off < 8'h06) && (endOff > 9'd4);
      strb.secCap    = IS_BRIDGE && ((off == 8'h19) || (off == 8'h18 && nBytes > 4'd1));
      strb.secHiLane = (off == 8'h18);
    end
  end

endmodule

// File: rtl/cfgspc_data.sv
module cfgspc_data
  import cfgspc_pkg::*;
#(
  parameter logic [15:0]             VENDOR_ID  = 16'hC0DE,
  parameter logic [15:0]             DEVICE_ID  = 16'h0042,
  parameter logic [15:0]             CLASS_CODE = 16'h0200,
  parameter bit                      IS_BRIDGE  = 1'b0,
  parameter int                      NUM_BARS   = 6,
  parameter logic [NUM_BARS*32-1:0]  BAR_SIZES  = '0,
  parameter logic [NUM_BARS*8-1:0]   BAR_TYPES  = '0,
  parameter logic [31:0]             ROM_SIZE   = 32'h0
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strb,
  input  logic [31:0] reqWdata,
  output logic        rdValid,
  output logic [31:0] rdData,
  output logic        cmdUpdate,
  output logic [7:0]  secBus,
  output logic [7:0]  hdrType
);

  logic [7:0]  cfgMem [REG_BYTES];
  logic [31:0] selSize, selType, barVal, romVal, rdNext;
  logic [7:0]  laneData [4];
  logic [7:0]  rdByte [4];

  function automatic logic [7:0] resetByte(input int a);
    logic [7:0] v;
    case (a)
      'h00:    v = VENDOR_ID[7:0];
      'h01:    v = VENDOR_ID[15:8];
      'h02:    v = DEVICE_ID[7:0];
      'h03:    v = DEVICE_ID[15:8];
      'h0A:    v = CLASS_CODE[7:0];
      'h0B:    v = CLASS_CODE[15:8];
      'h0E:    v = IS_BRIDGE ? HDR_BRIDGE : HDR_PLAIN;
      default: v = 8'h00;
    endcase
    if (IS_BRIDGE) begin
      case (a)
        'h04:    v = 8'h06;
        'h06:    v = 8'hA0;
        'h0D:    v = 8'h10;
        'h1E:    v = 8'hA0;
        default: ;
      endcase
    end
    for (int b = 0; b < NUM_BARS; b++)
      if (a == int'(BAR_LO) + 4 * b && BAR_SIZES[32*b +: 32] != '0)
        v = BAR_TYPES[8*b +: 8];
    return v;
  endfunction

  always_comb begin
    selSize = '0;
    selType = '0;
    for (int b = 0; b < NUM_BARS; b++)
      if (strb.barSel == 3'(b)) begin
        selSize = BAR_SIZES[32*b +: 32];
        selType = {24'b0, BAR_TYPES[8*b +: 8]};
      end
  end

  assign barVal = (reqWdata & ~(selSize - 32'd1)) | selType;
  assign romVal = reqWdata & (~(ROM_SIZE - 32'd1) | 32'd1);

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      laneData[i] = reqWdata[8*i +: 8] & keepMask(strb.offset + 8'(i));
      rdByte[i]   = cfgMem[8'(strb.offset + 8'(i))];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < REG_BYTES; a++) cfgMem[a] <= resetByte(a);
    end else if (strb.barWr) begin
      for (int i = 0; i < 4; i++) cfgMem[8'(strb.offset + 8'(i))] <= barVal[8*i +: 8];
    end else if (strb.romWr) begin
      for (int i = 0; i < 4; i++) cfgMem[8'(ROM_OFS + 8'(i))] <= romVal[8*i +: 8];
    end else begin
      for (int i = 0; i < 4; i++)
        if (strb.laneWe[i]) cfgMem[8'(strb.offset + 8'(i))] <= laneData[i];
    end
  end

  always_comb begin
    case (strb.rdWidth)
      RD_W1:   rdNext = strb.rdMiss ? 32'h0000_00FF : {24'b0, rdByte[0]};
      RD_W2:   rdNext = strb.rdMiss ? 32'h0000_FFFF : {16'b0, rdByte[1], rdByte[0]};
      default: rdNext = strb.rdMiss ? 32'hFFFF_FFFF :
                        {rdByte[3], rdByte[2], rdByte[1], rdByte[0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid   <= 1'b0;
      rdData    <= '0;
      cmdUpdate <= 1'b0;
      secBus    <= '0;
    end else begin
      rdValid   <= strb.rdEn;
      cmdUpdate <= strb.cmdTouch;
      if (strb.rdEn) rdData <= rdNext;
      if (strb.secCap) secBus <= strb.secHiLane ? reqWdata[15:8] : reqWdata[7:0];
    end
  end

  assign hdrType = cfgMem[HDR_OFS];

endmodule

// File: rtl/cfgspc_unit.sv
module cfgspc_unit
  import cfgspc_pkg::*;
#(
  parameter logic [7:0]              MY_BUS     = 8'h00,
  parameter logic [7:0]              MY_DEVFN   = 8'h18,
  parameter bit                      IS_BRIDGE  = 1'b0,
  parameter logic [15:0]             VENDOR_ID  = 16'hC0DE,
  parameter logic [15:0]             DEVICE_ID  = 16'h0042,
  parameter logic [15:0]             CLASS_CODE = 16'h0200,
  parameter int                      NUM_BARS   = 6,
  parameter logic [NUM_BARS*32-1:0]  BAR_SIZES  = {32'h0, 32'h0, 32'h0, 32'h10, 32'h1000, 32'h100},
  parameter logic [NUM_BARS*8-1:0]   BAR_TYPES  = {8'h00, 8'h00, 8'h00, 8'h08, 8'h00, 8'h01},
  parameter logic [31:0]             ROM_SIZE   = 32'h800
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [23:0] reqAddr,
  input  logic [2:0]  reqLen,
  input  logic [31:0] reqWdata,
  output logic        rdValid,
  output logic [31:0] rdData,
  output logic        cmdUpdate,
  output logic [7:0]  secBus
);

  ctrlStrobe_t strb;
  logic [7:0]  hdrType;

  cfgspc_ctrl #(
    .MY_BUS(MY_BUS), .MY_DEVFN(MY_DEVFN), .IS_BRIDGE(IS_BRIDGE),
    .NUM_BARS(NUM_BARS), .BAR_SIZES(BAR_SIZES), .ROM_SIZE(ROM_SIZE)
  ) u_ctrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqLen(reqLen), .hdrType(hdrType), .strb(strb)
  );

  cfgspc_data #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .CLASS_CODE(CLASS_CODE),
    .IS_BRIDGE(IS_BRIDGE), .NUM_BARS(NUM_BARS), .BAR_SIZES(BAR_SIZES),
    .BAR_TYPES(BAR_TYPES), .ROM_SIZE(ROM_SIZE)
  ) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .cmdUpdate(cmdUpdate),
    .secBus(secBus), .hdrType(hdrType)
  );

endmodule

// File: rtl/cfgspc_chk.sv
module cfgspc_chk #(
  parameter logic [7:0] MY_BUS   = 8'h00,
  parameter logic [7:0] MY_DEVFN = 8'h18
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWrite,
  input logic [23:0] reqAddr,
  input logic [2:0]  reqLen,
  input logic        rdValid,
  input logic [31:0] rdData,
  input logic        cmdUpdate,
  input logic [7:0]  secBus
);

  // R3
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(reqValid && !reqWrite));

  // R2
  miss_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(reqValid && !reqWrite && (reqAddr[23:8] != {MY_BUS, MY_DEVFN}) && reqLen == 3'd1)
      |-> (rdValid && rdData == 32'h0000_00FF));

  // R3
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(reqLen == 3'd1)) |-> (rdData[31:8] == 24'h0));

  // R11
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdUpdate |-> $past(reqValid && reqWrite && reqAddr[23:8] == {MY_BUS, MY_DEVFN}));

  // R12
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(reqValid && reqWrite) |-> $stable(secBus));

endmodule

bind cfgspc_unit cfgspc_chk #(.MY_BUS(MY_BUS), .MY_DEVFN(MY_DEVFN)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqAddr(reqAddr), .reqLen(reqLen), .rdValid(rdValid), .rdData(rdData),
  .cmdUpdate(cmdUpdate), .secBus(secBus)
);

// File: tb/test_cfgspc_unit.sv
`timescale 1ns/1ps
module test_cfgspc_unit;

  localparam logic [7:0] EP_DEV = 8'h18;
  localparam logic [7:0] BR_DEV = 8'h20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [23:0] reqAddr = '0;
  logic [2:0]  reqLen = 3'd4;
  logic [31:0] reqWdata = '0;
  logic        rdValidE, rdValidB, cmdE, cmdB;
  logic [31:0] rdDataE, rdDataB;
  logic [7:0]  secE, secB;

  int total = 0;
  int fails = 0;

  // bench-side reference state
  logic [7:0]  mdl [2][256];
  logic [31:0] barSz [2][6];
  logic [7:0]  barTy [2][6];
  logic [31:0] romSz [2];
  logic [7:0]  expSec;

  always #5 clk = ~clk;

  cfgspc_unit #(.MY_BUS(8'h00), .MY_DEVFN(EP_DEV), .IS_BRIDGE(1'b0),
    .VENDOR_ID(16'hC0DE), .DEVICE_ID(16'h0042), .CLASS_CODE(16'h0200),
    .BAR_SIZES({32'h0, 32'h0, 32'h0, 32'h10, 32'h1000, 32'h100}),
    .BAR_TYPES({8'h00, 8'h00, 8'h00, 8'h08, 8'h00, 8'h01}),
    .ROM_SIZE(32'h800)
  ) i_cfgspc_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqWdata(reqWdata),
    .rdValid(rdValidE), .rdData(rdDataE), .cmdUpdate(cmdE), .secBus(secE)
  );

  cfgspc_unit #(.MY_BUS(8'h00), .MY_DEVFN(BR_DEV), .IS_BRIDGE(1'b1),
    .VENDOR_ID(16'hB0B0), .DEVICE_ID(16'h0101), .CLASS_CODE(16'h0604),
    .BAR_SIZES('0), .BAR_TYPES('0), .ROM_SIZE(32'h0)
  ) i_cfgspc_unit_brg (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqWdata(reqWdata),
    .rdValid(rdValidB), .rdData(rdDataB), .cmdUpdate(cmdB), .secBus(secB)
  );

  task automatic modelInit();
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 256; a++) mdl[s][a] = 8'h00;
    barSz[0] = '{32'h100, 32'h1000, 32'h10, 32'h0, 32'h0, 32'h0};
    barTy[0] = '{8'h01, 8'h00, 8'h08, 8'h00, 8'h00, 8'h00};
    barSz[1] = '{default: 32'h0};
    barTy[1] = '{default: 8'h00};
    romSz[0] = 32'h800;
    romSz[1] = 32'h0;
    // R13 reset contents
    mdl[0][0] = 8'hDE; mdl[0][1] = 8'hC0; mdl[0][2] = 8'h42; mdl[0][3] = 8'h00;
    mdl[0][10] = 8'h00; mdl[0][11] = 8'h02; mdl[0][14] = 8'h00;
    mdl[0][16] = 8'h01; mdl[0][20] = 8'h00; mdl[0][24] = 8'h08;
    mdl[1][0] = 8'hB0; mdl[1][1] = 8'hB0; mdl[1][2] = 8'h01; mdl[1][3] = 8'h01;
    mdl[1][10] = 8'h04; mdl[1][11] = 8'h06; mdl[1][14] = 8'h81;
    mdl[1][4] = 8'h06; mdl[1][6] = 8'hA0; mdl[1][13] = 8'h10; mdl[1][30] = 8'hA0;
    expSec = 8'h00;
  endtask

  function automatic bit prot(int s, int a);
    bit plain, shared;
    plain  = (mdl[s][14] == 8'h00) || (mdl[s][14] == 8'h80);
    shared = (a <= 3) || (a >= 6 && a <= 11) || (a == 14) || (a >= 44 && a <= 47) || (a == 61);
    if (plain) return shared || (a >= 16 && a <= 39) || (a >= 48 && a <= 51);
    return shared || (a >= 56 && a <= 59);
  endfunction

  function automatic int lenBytes(logic [2:0] len);
    return (len == 3'd1) ? 1 : (len == 3'd2) ? 2 : 4;
  endfunction

  function automatic logic [31:0] modelRead(int s, int off, logic [2:0] len);
    int n, w;
    logic [31:0] v;
    n = lenBytes(len);
    if (n == 4 && off <= 252) w = 4;
    else if (n >= 2 && off <= 254) w = 2;
    else w = 1;
    v = '0;
    for (int i = 0; i < w; i++) v[8*i +: 8] = mdl[s][off + i];
    return v;
  endfunction

  task automatic modelWrite(int s, int off, logic [2:0] len, logic [31:0] d);
    int n;
    logic [31:0] v;
    logic [7:0] b;
    n = lenBytes(len);
    if (s == 1) begin
      if (off == 25) expSec = d[7:0];
      else if (off == 24 && n > 1) expSec = d[15:8];
    end
    if (n == 4 && off % 4 == 0 && off >= 16 && off < 40 && barSz[s][(off - 16) / 4] != 0) begin
      v = (d & ~(barSz[s][(off - 16) / 4] - 32'd1)) | {24'b0, barTy[s][(off - 16) / 4]};
      for (int i = 0; i < 4; i++) mdl[s][off + i] = v[8*i +: 8];
    end else if (n == 4 && off == 48 && romSz[s] != 0) begin
      v = d & (~(romSz[s] - 32'd1) | 32'd1);
      for (int i = 0; i < 4; i++) mdl[s][48 + i] = v[8*i +: 8];
    end else begin
      for (int i = 0; i < n; i++) begin
        if (off + i > 255) break;
        if (!prot(s, off + i)) begin
          b = d[8*i +: 8];
          if (off + i == 5) b = b & 8'h07;
          if (off + i == 6) b = b & 8'hF8;
          mdl[s][off + i] = b;
        end
      end
    end
  endtask

  task automatic check(string tag, string what, int s, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s dut%0d: actual %h expected %h", tag, what, s, act, exp);
    end
  endtask

  // one access per clock; outputs compared after the edge that registers them
  task automatic access(bit wr, logic [7:0] bus, logic [7:0] devfn, logic [7:0] off,
                        logic [2:0] len, logic [31:0] d, string tag);
    bit          hit [2];
    logic [31:0] expRd [2];
    bit          expCmd [2];
    int          n;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = {bus, devfn, off}; reqLen = len; reqWdata = d;
    n = lenBytes(len);
    for (int s = 0; s < 2; s++) begin
      hit[s] = (bus == 8'h00) && (devfn == ((s == 0) ? EP_DEV : BR_DEV));
      expRd[s] = '0;
      if (!wr) begin
        if (hit[s]) expRd[s] = modelRead(s, int'(off), len);
        else expRd[s] = (n == 1) ? 32'hFF : (n == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
      end
      expCmd[s] = wr && hit[s] && (int'(off) < 6) && (int'(off) + n > 4);
      if (wr && hit[s]) modelWrite(s, int'(off), len, d);
    end
    @(posedge clk);
    #1;
    reqValid = 1'b0;
    check(tag, "rdValid", 0, {31'b0, rdValidE}, {31'b0, !wr});
    check(tag, "rdValid", 1, {31'b0, rdValidB}, {31'b0, !wr});
    if (!wr) begin
      check(tag, "rdData", 0, rdDataE, expRd[0]);
      check(tag, "rdData", 1, rdDataB, expRd[1]);
    end
    check(tag, "cmdUpdate", 0, {31'b0, cmdE}, {31'b0, expCmd[0]});
    check(tag, "cmdUpdate", 1, {31'b0, cmdB}, {31'b0, expCmd[1]});
    check(tag, "secBus", 1, {24'b0, secB}, {24'b0, expSec});
  endtask

  task automatic rdBoth(logic [7:0] off, logic [2:0] len, string tag);
    access(1'b0, 8'h00, EP_DEV, off, len, 32'h0, tag);
    access(1'b0, 8'h00, BR_DEV, off, len, 32'h0, tag);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL R1 watchdog expired: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    modelInit();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R13 reset values of both flavours
    for (int a = 0; a < 64; a += 4) rdBoth(8'(a), 3'd4, "R13");

    // R2 misses at each width
    access(1'b0, 8'h01, EP_DEV, 8'h00, 3'd1, 0, "R2");
    access(1'b0, 8'h01, EP_DEV, 8'h00, 3'd2, 0, "R2");
    access(1'b0, 8'h00, 8'h19, 8'h04, 3'd4, 0, "R2");
    access(1'b0, 8'h00, 8'h08, 8'h04, 3'd3, 0, "R2");

    // R1 writes to foreign addresses do nothing
    access(1'b1, 8'h02, EP_DEV, 8'h40, 3'd4, 32'hDEADBEEF, "R1");
    access(1'b1, 8'h00, 8'h21, 8'h04, 3'd2, 32'hFFFF, "R1");
    access(1'b1, 8'h00, 8'h21, 8'h19, 3'd1, 32'h77, "R1");
    rdBoth(8'h40, 3'd4, "R1");

    // R3 R7 little-endian ordering, aligned and unaligned
    access(1'b1, 8'h00, EP_DEV, 8'h40, 3'd4, 32'h11223344, "R7");
    access(1'b0, 8'h00, EP_DEV, 8'h41, 3'd1, 0, "R3");
    access(1'b0, 8'h00, EP_DEV, 8'h42, 3'd2, 0, "R3");
    access(1'b0, 8'h00, EP_DEV, 8'h40, 3'd4, 0, "R3");
    access(1'b1, 8'h00, EP_DEV, 8'h45, 3'd2, 32'hAABBCCDD, "R7");
    access(1'b0, 8'h00, EP_DEV, 8'h44, 3'd4, 0, "R3");

    // R4 fallback near the top; R7 lanes past 0xFF dropped
    access(1'b1, 8'h00, EP_DEV, 8'hFC, 3'd4, 32'h9A8B7C6D, "R7");
    access(1'b0, 8'h00, EP_DEV, 8'hFD, 3'd4, 0, "R4");
    access(1'b0, 8'h00, EP_DEV, 8'hFF, 3'd4, 0, "R4");
    access(1'b0, 8'h00, EP_DEV, 8'hFF, 3'd2, 0, "R4");
    access(1'b1, 8'h00, EP_DEV, 8'hFE, 3'd4, 32'h55443322, "R7");
    access(1'b0, 8'h00, EP_DEV, 8'hFC, 3'd4, 0, "R7");
    access(1'b0, 8'h00, EP_DEV, 8'h00, 3'd4, 0, "R7");

    // R5 sized registers are masked, unsized stays protected
    access(1'b1, 8'h00, EP_DEV, 8'h10, 3'd4, 32'hFFFFFFFF, "R5");
    access(1'b1, 8'h00, EP_DEV, 8'h14, 3'd4, 32'h12345678, "R5");
    access(1'b1, 8'h00, EP_DEV, 8'h18, 3'd4, 32'hABCDEF07, "R5");
    access(1'b1, 8'h00, EP_DEV, 8'h1C, 3'd4, 32'hFFFFFFFF, "R5");
    access(1'b1, 8'h00, EP_DEV, 8'h10, 3'd1, 32'h000000F0, "R5");
    for (int a = 16; a < 40; a += 4) access(1'b0, 8'h00, EP_DEV, 8'(a), 3'd4, 0, "R5");

    // R6 ROM register keeps its enable bit
    access(1'b1, 8'h00, EP_DEV, 8'h30, 3'd4, 32'hFFFFFFFF, "R6");
    access(1'b0, 8'h00, EP_DEV, 8'h30, 3'd4, 0, "R6");
    access(1'b1, 8'h00, EP_DEV, 8'h30, 3'd4, 32'h00012346, "R6");
    access(1'b0, 8'h00, EP_DEV, 8'h30, 3'd4, 0, "R6");
    access(1'b1, 8'h00, EP_DEV, 8'h30, 3'd2, 32'h0000FFFF, "R6");
    access(1'b0, 8'h00, EP_DEV, 8'h30, 3'd4, 0, "R6");

    // R8 plain header protection
    access(1'b1, 8'h00, EP_DEV, 8'h00, 3'd4, 32'hFFFFFFFF, "R8");
    access(1'b1, 8'h00, EP_DEV, 8'h2C, 3'd4, 32'hFFFFFFFF, "R8");
    access(1'b1, 8'h00, EP_DEV, 8'h3C, 3'd4, 32'hFFFFFFFF, "R8");
    access(1'b1, 8'h00, EP_DEV, 8'h38, 3'd4, 32'h01020304, "R8");
    access(1'b1, 8'h00, EP_DEV, 8'h0C, 3'd4, 32'hFFFFFFFF, "R8");
    for (int a = 0; a < 64; a += 4) access(1'b0, 8'h00, EP_DEV, 8'(a), 3'd4, 0, "R8");

    // R9 bridge header protection
    access(1'b1, 8'h00, BR_DEV, 8'h10, 3'd4, 32'h87654321, "R9");
    access(1'b1, 8'h00, BR_DEV, 8'h30, 3'd4, 32'hCAFEF00D, "R9");
    access(1'b1, 8'h00, BR_DEV, 8'h38, 3'd4, 32'hFFFFFFFF, "R9");
    access(1'b1, 8'h00, BR_DEV, 8'h08, 3'd4, 32'hFFFFFFFF, "R9");
    access(1'b1, 8'h00, BR_DEV, 8'h3C, 3'd4, 32'hFFFFFFFF, "R9");
    for (int a = 0; a < 64; a += 4) access(1'b0, 8'h00, BR_DEV, 8'(a), 3'd4, 0, "R9");

    // R10 reserved command bits; R11 remap pulse boundaries
    access(1'b1, 8'h00, EP_DEV, 8'h04, 3'd2, 32'h0000FFFF, "R10");
    access(1'b0, 8'h00, EP_DEV, 8'h04, 3'd4, 0, "R10");
    access(1'b1, 8'h00, EP_DEV, 8'h05, 3'd1, 32'h000000AA, "R10");
    access(1'b0, 8'h00, EP_DEV, 8'h05, 3'd1, 0, "R10");
    access(1'b1, 8'h00, EP_DEV, 8'h03, 3'd1, 32'h0, "R11");
    access(1'b1, 8'h00, EP_DEV, 8'h03, 3'd2, 32'h0, "R11");
    access(1'b1, 8'h00, EP_DEV, 8'h02, 3'd4, 32'h0, "R11");
    access(1'b1, 8'h00, EP_DEV, 8'h06, 3'd1, 32'h0, "R11");
    access(1'b1, 8'h00, BR_DEV, 8'h05, 3'd1, 32'h0, "R11");
    access(1'b0, 8'h00, EP_DEV, 8'h04, 3'd2, 0, "R11");

    // R12 secondary bus capture on the bridge
    access(1'b1, 8'h00, BR_DEV, 8'h19, 3'd1, 32'h00000005, "R12");
    access(1'b1, 8'h00, BR_DEV, 8'h18, 3'd2, 32'h00000A09, "R12");
    access(1'b1, 8'h00, BR_DEV, 8'h18, 3'd1, 32'h000000EE, "R12");
    access(1'b1, 8'h00, BR_DEV, 8'h18, 3'd4, 32'h44332211, "R12");
    access(1'b1, 8'h00, BR_DEV, 8'h1A, 3'd1, 32'h00000033, "R12");
    access(1'b1, 8'h00, EP_DEV, 8'h19, 3'd1, 32'h0000007F, "R12");
    access(1'b0, 8'h00, BR_DEV, 8'h18, 3'd4, 0, "R12");
    total++;
    if (secE !== 8'h00) begin
      fails++;
      $display("FAIL R12 secBus plain dut: actual %h expected 00", secE);
    end

    repeat (2) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

endmodule